// File: doc/BRIEF.md
# Radix-4 Combined Digit Selection

This block chooses the next result digit of a radix-4 recurrence that is shared between division and square root. Each step it receives the carry-save residual as two words, the normalised divisor, the partial root built so far, a select that says which operation is running, and a flag that marks the first iteration. It returns one digit from the set {-2,-1,0,+1,+2} as four one-hot select lines and a sign flag. The surrounding datapath uses these lines to pick the multiple that updates the residual.

The block first adds the top bits of the two residual words in a narrow carry-propagate adder. This gives a short signed estimate of four times the residual. It then builds a 3-bit index that names which of eight sixteenth-wide intervals the normalised operand lies in. The operand is the divisor during division and the partial root during square root. Both operations use one threshold table. The estimate is compared against the four thresholds of the selected interval. The block is purely combinational.

All words are `W` bits wide and have one integer bit in the most significant position. The residual words are two's complement. The divisor and root are unsigned, with bit `W-2` weighing 1/2.

Top module: `dsel_r4_top`

## Requirements
- R1: The estimate is formed from bits `[W-1:W-8]` of each residual word. These two 8-bit slices are added modulo 256. Bits 7..1 of the sum are read as a 7-bit two's-complement value in units of 1/16. No carry from the lower residual bits enters this sum.
- R2: Residual bits below the two 8-bit slices have no effect on the outputs.
- R3: In division (`op_sqrt`=0), the interval index is divisor bits `[W-3:W-5]`, which weigh 2^-2, 2^-3 and 2^-4. In this mode the first-iteration flag and the root input have no effect.
- R4: In square root with `first_iter`=1, the index is the fixed value 3'b100, whatever the root holds.
- R5: In square root with `first_iter`=0 and root bit `W-1` (the integer bit) set to 1, the index is 3'b111.
- R6: In square root with `first_iter`=0 and root bit `W-1` clear, the index is root bits `[W-3:W-5]`.
- R7: The thresholds, in sixteenths, for index values 0 through 7 are as follows. The +2 threshold is 12,14,15,16,18,20,20,22. The +1 threshold is 4,4,4,4,6,6,8,8. The 0 threshold is -4,-5,-6,-6,-6,-8,-8,-8. The -1 threshold is -13,-15,-16,-17,-18,-20,-22,-23. An estimate in [-4,3] therefore always gives digit 0.
- R8: The digit is the largest h whose threshold is at or below the estimate. This gives +2 for an estimate at or above the +2 threshold, and -2 for an estimate below the -1 threshold.
- R9: The outputs `dig_p2`, `dig_p1`, `dig_m1` and `dig_m2` stand for +2, +1, -1 and -2. Exactly one of them is high for a non-zero digit, and none is high for digit 0.
- R10: `dig_neg` is high exactly when the digit is -1 or -2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| res_sum | input | W | Sum word of the carry-save residual |
| res_carry | input | W | Carry word of the carry-save residual |
| divisor | input | W | Normalised divisor |
| root | input | W | Partial root from the conversion logic |
| op_sqrt | input | 1 | 1 for square root, 0 for division |
| first_iter | input | 1 | High during iteration j=0 |
| dig_p2 | output | 1 | Digit is +2 |
| dig_p1 | output | 1 | Digit is +1 |
| dig_m1 | output | 1 | Digit is -1 |
| dig_m2 | output | 1 | Digit is -2 |
| dig_neg | output | 1 | Digit is negative |

## Verification
For each way of forming the index, the bench sweeps every 8-bit sum of the residual slices across all eight intervals. These ways are division, square root in the first iteration, square root with the integer bit set, and square root with the integer bit clear. Every threshold crossing is therefore seen from both sides.

The residual slices are split between the two words in varying ways, so that wrap-around of the narrow sum is exercised. The lower residual bits are random, which separates a correct truncated adder from one that lets a carry in from below. The operand bits that the index must ignore are also random. In division this includes the flag and the root, and in the fixed-index and integer-bit cases it includes the lower root bits. This exposes an index drawn from the wrong source.

// File: rtl/dsel_pkg.sv
// Package: shared widths and the threshold table of the radix-4 digit selector.
// Assumes: estimates are signed sixteenths, and the index names intervals 8/16..15/16.
package dsel_pkg;

    localparam int EST_W     = 7;             // signed estimate width in sixteenths
    localparam int SUM_W     = EST_W + 1;     // width of the truncated residual adder
    localparam int IDX_W     = 3;             // interval index width
    localparam int NLVL      = 4;             // thresholds per interval
    localparam logic [IDX_W-1:0] FIRST_IDX = 3'b100;

    typedef logic signed [EST_W-1:0] est_t;
    typedef logic [IDX_W-1:0]        idx_t;

    // Level 0..3 selects the +2, +1, 0 and -1 thresholds of interval idx.
    function automatic est_t thr_lookup(input int unsigned lvl, input idx_t idx);
        est_t r;
        r = '0;
        case (lvl)
            0: case (idx)
                3'd0: r = est_t'(12);
                3'd1: r = est_t'(14);
                3'd2: r = est_t'(15);
                3'd3: r = est_t'(16);
                3'd4: r = est_t'(18);
                3'd5: r = est_t'(20);
                3'd6: r = est_t'(20);
                default: r = est_t'(22);
            endcase
            1: case (idx)
                3'd0, 3'd1, 3'd2, 3'd3: r = est_t'(4);
                3'd4, 3'd5:             r = est_t'(6);
                default:                r = est_t'(8);
            endcase
            2: case (idx)
                3'd0:             r = est_t'(-4);
                3'd1:             r = est_t'(-5);
                3'd2, 3'd3, 3'd4: r = est_t'(-6);
                default:          r = est_t'(-8);
            endcase
            default: case (idx)
                3'd0: r = est_t'(-13);
                3'd1: r = est_t'(-15);
                3'd2: r = est_t'(-16);
                3'd3: r = est_t'(-17);
                3'd4: r = est_t'(-18);
                3'd5: r = est_t'(-20);
                3'd6: r = est_t'(-22);
                default: r = est_t'(-23);
            endcase
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dsel_estimate.sv
// Module: truncated carry-propagate adder that turns the two top residual
// slices into a signed estimate of four times the residual.
// Assumes: the slices are already cut from the words, and lower bits are dropped.
module dsel_estimate
    import dsel_pkg::*;
(
    input  logic [SUM_W-1:0] slice_s,
    input  logic [SUM_W-1:0] slice_c,
    output est_t             est
);

    logic [SUM_W-1:0] sum_q;

    // Add the slices modulo 2^SUM_W and drop the lowest sum bit.
    always_comb begin
        sum_q = slice_s + slice_c;
        est   = est_t'(sum_q[SUM_W-1:1]);
    end

endmodule

// File: rtl/dsel_index.sv
// Module: chooses the 3-bit interval index from the divisor or the partial root.
// Assumes: root_int is the integer bit, and the frac inputs weigh 2^-2..2^-4.
module dsel_index
    import dsel_pkg::*;
(
    input  idx_t div_frac,
    input  idx_t root_frac,
    input  logic root_int,
    input  logic op_sqrt,
    input  logic first_iter,
    output idx_t idx
);

    // Priority: division, then the first root step, then a root of one, then the root bits.
    always_comb begin
        if (!op_sqrt)
            idx = div_frac;
        else if (first_iter)
            idx = FIRST_IDX;
        else if (root_int)
            idx = '1;
        else
            idx = root_frac;
    end

endmodule

// File: rtl/dsel_compare.sv
// Module: compares the estimate against the four thresholds of one interval
// and encodes the outcome as one-hot digit lines plus a sign.
// Assumes: the thresholds fall strictly from level 0 to level 3 in every interval.
module dsel_compare
    import dsel_pkg::*;
(
    input  est_t est,
    input  idx_t idx,
    output logic p2,
    output logic p1,
    output logic m1,
    output logic m2,
    output logic neg
);

    logic [NLVL-1:0] ge;

    // One comparator per threshold level; ge[l] means the estimate is at or above level l.
    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        assign ge[l] = (est >= thr_lookup(l, idx));
    end

    // Decode the thermometer into one-hot digit lines.
    always_comb begin
        p2  = ge[0];
        p1  = ge[1] & ~ge[0];
        m1  = ge[3] & ~ge[2];
        m2  = ~ge[3];
        neg = ~ge[2];
    end

    // The comparator outputs must form a thermometer, and the digit lines must be consistent.
    always_comb begin
        assert_thermo_order_R8: assert ((!ge[0] || ge[1]) && (!ge[1] || ge[2]) && (!ge[2] || ge[3]));
        assert_onehot_R9: assert ($onehot0({p2, p1, m1, m2}));
        assert_sign_R10: assert (neg == (m1 | m2));
    end

endmodule

// File: rtl/dsel_r4_top.sv
// Module: radix-4 digit selection shared by division and square root.
// Slices the residual words, forms the estimate and index, and selects the digit.
// Assumes: all words are W bits wide, with the integer bit at W-1.
module dsel_r4_top
    import dsel_pkg::*;
#(
    parameter int W = 56
) (
    input  logic [W-1:0] res_sum,
    input  logic [W-1:0] res_carry,
    input  logic [W-1:0] divisor,
    input  logic [W-1:0] root,
    input  logic         op_sqrt,
    input  logic         first_iter,
    output logic         dig_p2,
    output logic         dig_p1,
    output logic         dig_m1,
    output logic         dig_m2,
    output logic         dig_neg
);

    localparam int SL_LO = W - SUM_W;       // lowest residual bit kept
    localparam int FR_HI = W - 3;           // operand bit of weight 2^-2
    localparam int FR_LO = FR_HI - IDX_W + 1;

    est_t est;
    idx_t idx;

    dsel_estimate u_est (
        .slice_s (res_sum[W-1:SL_LO]),
        .slice_c (res_carry[W-1:SL_LO]),
        .est     (est)
    );

    dsel_index u_idx (
        .div_frac   (divisor[FR_HI:FR_LO]),
        .root_frac  (root[FR_HI:FR_LO]),
        .root_int   (root[W-1]),
        .op_sqrt    (op_sqrt),
        .first_iter (first_iter),
        .idx        (idx)
    );

    dsel_compare u_cmp (
        .est (est),
        .idx (idx),
        .p2  (dig_p2),
        .p1  (dig_p1),
        .m1  (dig_m1),
        .m2  (dig_m2),
        .neg (dig_neg)
    );

    // Gathers the operand bits the selection never looks at.
    logic unused_bits;
    assign unused_bits = ^{res_sum[SL_LO-1:0], res_carry[SL_LO-1:0],
                           divisor[W-1:W-2], divisor[FR_LO-1:0],
                           root[W-2], root[FR_LO-1:0]};

    // Estimates outside every interval's thresholds have a fixed digit.
    always_comb begin
        if (est >= est_t'(22)) begin
            assert_big_est_R8: assert (dig_p2);
        end
        if (est < est_t'(-23)) begin
            assert_small_est_R8: assert (dig_m2);
        end
        if (est >= est_t'(-4) && est <= est_t'(3)) begin
            assert_zero_band_R7: assert (!(dig_p2 | dig_p1 | dig_m1 | dig_m2 | dig_neg));
        end
    end

endmodule

// File: tb/sim_dsel_r4_top.sv
// Bench: sweeps every estimate in every interval for each index source and
// compares the outputs against a behavioural integer model.
module sim_dsel_r4_top;

    localparam int W = 56;

    logic         clk = 1'b0;
    logic [W-1:0] res_sum, res_carry, divisor, root;
    logic         op_sqrt, first_iter;
    logic         dig_p2, dig_p1, dig_m1, dig_m2, dig_neg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int t_p2 [8] = '{12, 14, 15, 16, 18, 20, 20, 22};
    int t_p1 [8] = '{4, 4, 4, 4, 6, 6, 8, 8};
    int t_z  [8] = '{-4, -5, -6, -6, -6, -8, -8, -8};
    int t_m1 [8] = '{-13, -15, -16, -17, -18, -20, -22, -23};

    always #10 clk = ~clk;   // 50 MHz

    dsel_r4_top #(.W(W)) u0 (
        .res_sum    (res_sum),
        .res_carry  (res_carry),
        .divisor    (divisor),
        .root       (root),
        .op_sqrt    (op_sqrt),
        .first_iter (first_iter),
        .dig_p2     (dig_p2),
        .dig_p1     (dig_p1),
        .dig_m1     (dig_m1),
        .dig_m2     (dig_m2),
        .dig_neg    (dig_neg)
    );

    function automatic logic [W-1:0] rnd_word();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[W-1:0];
    endfunction

    function automatic int model_digit(int est, int idx);
        if (est >= t_p2[idx]) return 2;
        if (est >= t_p1[idx]) return 1;
        if (est >= t_z[idx])  return 0;
        if (est >= t_m1[idx]) return -1;
        return -2;
    endfunction

    // scen 0: division, 1: root first step, 2: root with integer bit, 3: root fraction bits
    task automatic run_case(int scen, int idx, int s8, int split, string tag);
        logic [7:0] a8, b8;
        int e7, est, exp_idx, dg;
        logic [4:0] exp_v, got_v;
        @(posedge clk);
        a8 = 8'(split);
        b8 = 8'(s8 - split);
        res_sum   = rnd_word();
        res_carry = rnd_word();
        res_sum[W-1 -: 8]   = a8;
        res_carry[W-1 -: 8] = b8;
        divisor = rnd_word();
        root    = rnd_word();
        first_iter = 1'($urandom());
        op_sqrt = (scen != 0);
        case (scen)
            0: begin divisor[W-3 -: 3] = 3'(idx); exp_idx = idx; end
            1: begin first_iter = 1'b1; exp_idx = 4; end
            2: begin first_iter = 1'b0; root[W-1] = 1'b1; exp_idx = 7; end
            default: begin
                first_iter = 1'b0; root[W-1] = 1'b0;
                root[W-3 -: 3] = 3'(idx); exp_idx = idx;
            end
        endcase
        e7  = ((int'(a8) + int'(b8)) % 256) / 2;
        est = (e7 >= 64) ? e7 - 128 : e7;
        dg  = model_digit(est, exp_idx);
        exp_v = {dg == 2, dg == 1, dg == -1, dg == -2, dg < 0};
        @(negedge clk);
        got_v = {dig_p2, dig_p1, dig_m1, dig_m2, dig_neg};
        n_chk++;
        if (got_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s est=%0d idx=%0d got=%b exp=%b", tag, est, exp_idx, got_v, exp_v);
        end
    endtask

    initial begin
        res_sum = '0; res_carry = '0; divisor = '0; root = '0;
        op_sqrt = 1'b0; first_iter = 1'b0;
        // Zero residual: digit 0 in every interval (R7, R9, R10).
        for (int i = 0; i < 8; i++) run_case(0, i, 0, 0, "R7/R9/R10 zero residual");
        for (int s = 0; s < 256; s++)
            for (int i = 0; i < 8; i++)
                run_case(0, i, s, (s * 37 + i * 91) & 255, "R1/R2/R3/R7/R8/R9/R10 division");
        for (int s = 0; s < 256; s++)
            run_case(1, 0, s, (s * 53 + 17) & 255, "R1/R2/R4/R8 root first step");
        for (int s = 0; s < 256; s++)
            run_case(2, 0, s, (s * 29 + 200) & 255, "R1/R2/R5/R8 root integer bit");
        for (int s = 0; s < 256; s++)
            for (int i = 0; i < 8; i++)
                run_case(3, i, s, (s * 71 + i * 13) & 255, "R1/R2/R6/R7/R8/R9/R10 root fraction");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule